// File: doc/BRIEF.md
# Iterative Byte/Word Shifter with Flag Update

This block performs one of three shift operations (shift left, arithmetic shift right, logical shift right) on an 8-bit or 16-bit operand. A start strobe latches the operation, the width, the operand, an 8-bit raw count and the current flag values. The unit then moves the operand by one bit position on each clock until the effective count is used up. Only the low five bits of the raw count form that effective count.

When the run ends, the block presents the result and a new set of carry, parity, zero, sign and overflow values. It also presents a write-enable mask that tells the surrounding flag register which of those values to take. A one-cycle done pulse marks the moment. Overflow is only defined for a single-position shift. A zero effective count writes no flag at all.

Top module: `shift_seq_unit`

## Requirements
- R1: The effective count is `count[4:0]` (0 to 31). Bits `count[7:5]` have no effect on the result, the flags, the write mask or the latency.
- R2: With `op` = 0 (shift left), each step moves the value one position toward the high end and fills bit 0 with 0. The bit that leaves the top is the step's carry-out.
- R3: With `op` = 1 (arithmetic shift right), each step keeps the top bit at the selected width unchanged and shifts the rest downward. Bit 0 leaves as the carry-out.
- R4: With `op` = 2 or 3 (logical shift right), each step fills the top bit at the selected width with 0. Bit 0 leaves as the carry-out.
- R5: The unit makes exactly one bit step per clock. If the start strobe is sampled at clock edge T and the effective count is N, `done` is high for the one cycle that follows edge T+N.
- R6: When N = 1, `flags_we[4]` is 1 and `flags_out[4]` (overflow) is set as follows. For shift left it is the XOR of the two top bits of the original operand. For arithmetic shift right it is 0. For logical shift right it is the original top bit.
- R7: When N = 0, `flags_we` is all zero, `flags_out` equals the `flags_in` value sampled at start, and `result` equals the operand at the selected width. `done` is high for the cycle after the start edge.
- R8: When N is nonzero, `flags_we[3:0]` are all 1. Carry (bit 0) is the last bit shifted out. Parity (bit 1) is 1 when `result[7:0]` holds an even number of ones. Zero (bit 2) is 1 when the result at the selected width is all zeros. Sign (bit 3) is the top bit of the result at the selected width.
- R9: When N > 1, `flags_we[4]` is 0 and `flags_out[4]` equals `flags_in[4]` as sampled at start.
- R10: A count larger than the operand width keeps stepping. Left and logical right shifts reach 0 with carry 0. The arithmetic right shift reaches all copies of the sign bit, with carry equal to the sign bit.
- R11: A start strobe that arrives while a run is in progress is ignored. `done` lasts one cycle. `result`, `flags_out` and `flags_we` stay unchanged from `done` until a later start produces a new completion.
- R12: `wide` = 0 selects 8-bit operation and then `result[15:8]` is 0. `wide` = 1 selects 16-bit operation. The flag vector bit order is {overflow, sign, zero, parity, carry} from bit 4 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a shift; sampled only while idle |
| op | input | 2 | 0 shift left, 1 arithmetic right, 2 or 3 logical right |
| wide | input | 1 | 0 selects 8 bits, 1 selects 16 bits |
| operand | input | 16 | Value to shift |
| count | input | 8 | Raw shift count; only bits 4:0 are used |
| flags_in | input | 5 | Incoming flags {ov, sign, zero, parity, carry} |
| result | output | 16 | Shifted value |
| flags_out | output | 5 | New flag values {ov, sign, zero, parity, carry} |
| flags_we | output | 5 | Per-flag write enable, same bit order |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result becomes due N+1 clock edges after the start edge, where N is the effective count. That is one edge to latch the inputs and one edge per step; for N = 0 the result is due one edge after the start edge. The bench drives inputs on the falling edge and then waits exactly N falling edges. At each of them it checks that `done` is still low. After the last one it checks `done`, the result, the flags and the write mask together, and one edge later it checks that `done` has dropped and the outputs held. Some runs raise a second start strobe one edge into the run, which must change nothing within that window.

// File: rtl/shseq_pkg.sv
package shseq_pkg;

    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 5;
    localparam int RAW_CNT_W = 8;
    localparam int NFLAGS    = 5;
    localparam int PAD_W     = WORD_W - BYTE_W;

    typedef enum logic [1:0] {
        OP_SHL     = 2'd0,
        OP_SAR     = 2'd1,
        OP_SHR     = 2'd2,
        OP_SHR_ALT = 2'd3
    } shop_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    // bit 4 down to bit 0
    typedef struct packed {
        logic ov;
        logic sg;
        logic zr;
        logic pa;
        logic cy;
    } flags_t;

    typedef struct packed {
        logic [WORD_W-1:0] val;
        logic              out;
    } step_t;

    function automatic logic [WORD_W-1:0] fit_width(input logic wide, input logic [WORD_W-1:0] v);
        return wide ? v : {{PAD_W{1'b0}}, v[BYTE_W-1:0]};
    endfunction

    function automatic logic top_of(input logic wide, input logic [WORD_W-1:0] v);
        return wide ? v[WORD_W-1] : v[BYTE_W-1];
    endfunction

    function automatic logic second_of(input logic wide, input logic [WORD_W-1:0] v);
        return wide ? v[WORD_W-2] : v[BYTE_W-2];
    endfunction

    function automatic logic even_parity(input logic [BYTE_W-1:0] b);
        return ~^b;
    endfunction

    // One bit step of the selected operation at the selected width.
    function automatic step_t shift_once(input shop_e op, input logic wide, input logic [WORD_W-1:0] v);
        step_t s;
        s = '0;
        case (op)
            OP_SHL: begin
                s.out = top_of(wide, v);
                s.val = fit_width(wide, {v[WORD_W-2:0], 1'b0});
            end
            OP_SAR: begin
                s.out = v[0];
                if (wide) s.val = {v[WORD_W-1], v[WORD_W-1:1]};
                else      s.val = {{PAD_W{1'b0}}, v[BYTE_W-1], v[BYTE_W-1:1]};
            end
            default: begin
                s.out = v[0];
                if (wide) s.val = {1'b0, v[WORD_W-1:1]};
                else      s.val = {{PAD_W{1'b0}}, 1'b0, v[BYTE_W-1:1]};
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/shseq_ctrl.sv
module shseq_ctrl
    import shseq_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int RCW = RAW_CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [RCW-1:0] raw_count,
    output logic           load,
    output logic           zero_req,
    output logic           step_en,
    output logic           last_step,
    output logic           single,
    output logic           busy
);

    logic [CW-1:0] eff;
    logic [CW-1:0] cnt_q;
    state_e        state_q;
    logic          unused_cnt_hi;

    assign eff           = raw_count[CW-1:0];
    assign unused_cnt_hi = ^raw_count[RCW-1:CW];

    assign busy      = (state_q == ST_RUN);
    assign load      = start && !busy;
    assign zero_req  = load && (eff == '0);
    assign step_en   = busy;
    assign last_step = busy && (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            single  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (load && (eff != '0)) begin
                        state_q <= ST_RUN;
                        cnt_q   <= eff;
                        single  <= (eff == CW'(1));
                    end
                end
                default: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CW'(1)) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // R5: one step per clock while more than one remains
    a_r5_one_step_per_clock: assert property (@(posedge clk) disable iff (rst)
        (busy && (cnt_q > CW'(1))) |=> (busy && (cnt_q == $past(cnt_q) - 1'b1)));

    // R1: a run starts with the low count bits only
    a_r1_count_masked: assert property (@(posedge clk) disable iff (rst)
        (load && !zero_req) |=> (cnt_q == $past(raw_count[CW-1:0])));

    // R5: the last step returns the unit to idle
    a_r5_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        last_step |=> !busy);

endmodule

// File: rtl/shseq_datapath.sv
module shseq_datapath
    import shseq_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int B = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step_en,
    input  shop_e        op_in,
    input  logic         wide_in,
    input  logic [W-1:0] operand,
    output logic [W-1:0] work_q,
    output shop_e        op_q,
    output logic         wide_q,
    output logic         orig_top_q,
    output logic         orig_second_q,
    output step_t        nxt
);

    assign nxt = shift_once(op_q, wide_q, work_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q        <= '0;
            op_q          <= OP_SHL;
            wide_q        <= 1'b0;
            orig_top_q    <= 1'b0;
            orig_second_q <= 1'b0;
        end else if (load) begin
            work_q        <= fit_width(wide_in, operand);
            op_q          <= op_in;
            wide_q        <= wide_in;
            orig_top_q    <= top_of(wide_in, operand);
            orig_second_q <= second_of(wide_in, operand);
        end else if (step_en) begin
            work_q <= nxt.val;
        end
    end

    // R2: a left step leaves bit 0 clear
    a_r2_low_fill: assert property (@(posedge clk) disable iff (rst)
        (step_en && op_q == OP_SHL) |=> (work_q[0] == 1'b0));

    // R3: an arithmetic right step keeps the top bit
    a_r3_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (step_en && op_q == OP_SAR) |=> (top_of(wide_q, work_q) == $past(top_of(wide_q, work_q))));

    // R4: a logical right step clears the top bit
    a_r4_high_fill: assert property (@(posedge clk) disable iff (rst)
        (step_en && (op_q == OP_SHR || op_q == OP_SHR_ALT)) |=> (top_of(wide_q, work_q) == 1'b0));

    // R12: byte mode never carries data above the low byte
    a_r12_byte_upper_clear: assert property (@(posedge clk) disable iff (rst)
        !wide_q |-> (work_q[W-1:B] == '0));

endmodule

// File: rtl/shseq_flags.sv
module shseq_flags
    import shseq_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int B = BYTE_W
) (
    input  shop_e        op,
    input  logic         wide,
    input  logic [W-1:0] val,
    input  logic         cout,
    input  logic         single,
    input  logic         orig_top,
    input  logic         orig_second,
    input  flags_t       fin,
    output flags_t       fl,
    output flags_t       we
);

    logic ov_calc;

    always_comb begin
        case (op)
            OP_SHL:  ov_calc = orig_top ^ orig_second;
            OP_SAR:  ov_calc = 1'b0;
            default: ov_calc = orig_top;
        endcase
    end

    always_comb begin
        fl.cy = cout;
        fl.pa = even_parity(val[B-1:0]);
        fl.zr = wide ? (val == '0) : (val[B-1:0] == '0);
        fl.sg = top_of(wide, val);
        fl.ov = single ? ov_calc : fin.ov;
        we    = '{ov: single, sg: 1'b1, zr: 1'b1, pa: 1'b1, cy: 1'b1};
    end

    // R8: a zero result cannot carry a set sign bit
    always_comb begin
        a_r8_zero_sign_excl: assert (!(fl.zr && fl.sg));
    end

endmodule

// File: rtl/shift_seq_unit.sv
module shift_seq_unit
    import shseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           op,
    input  logic                 wide,
    input  logic [WORD_W-1:0]    operand,
    input  logic [RAW_CNT_W-1:0] count,
    input  logic [NFLAGS-1:0]    flags_in,
    output logic [WORD_W-1:0]    result,
    output logic [NFLAGS-1:0]    flags_out,
    output logic [NFLAGS-1:0]    flags_we,
    output logic                 done
);

    logic              load, zero_req, step_en, last_step, single, busy;
    logic [WORD_W-1:0] work_q;
    shop_e             op_q;
    logic              wide_q, orig_top_q, orig_second_q;
    step_t             nxt;
    flags_t            fin_q, fl_calc, we_calc;

    shseq_ctrl #(.CW(CNT_W), .RCW(RAW_CNT_W)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .raw_count (count),
        .load      (load),
        .zero_req  (zero_req),
        .step_en   (step_en),
        .last_step (last_step),
        .single    (single),
        .busy      (busy)
    );

    shseq_datapath #(.W(WORD_W), .B(BYTE_W)) i_dp (
        .clk           (clk),
        .rst           (rst),
        .load          (load),
        .step_en       (step_en),
        .op_in         (shop_e'(op)),
        .wide_in       (wide),
        .operand       (operand),
        .work_q        (work_q),
        .op_q          (op_q),
        .wide_q        (wide_q),
        .orig_top_q    (orig_top_q),
        .orig_second_q (orig_second_q),
        .nxt           (nxt)
    );

    shseq_flags #(.W(WORD_W), .B(BYTE_W)) i_flags (
        .op          (op_q),
        .wide        (wide_q),
        .val         (nxt.val),
        .cout        (nxt.out),
        .single      (single),
        .orig_top    (orig_top_q),
        .orig_second (orig_second_q),
        .fin         (fin_q),
        .fl          (fl_calc),
        .we          (we_calc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fin_q     <= '0;
            result    <= '0;
            flags_out <= '0;
            flags_we  <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) fin_q <= flags_t'(flags_in);
            if (zero_req) begin
                result    <= fit_width(wide, operand);
                flags_out <= flags_in;
                flags_we  <= '0;
                done      <= 1'b1;
            end else if (last_step) begin
                result    <= nxt.val;
                flags_out <= fl_calc;
                flags_we  <= we_calc;
                done      <= 1'b1;
            end
        end
    end

    // R7: a zero count completes next cycle with no flag written
    a_r7_zero_count_quiet: assert property (@(posedge clk) disable iff (rst)
        zero_req |=> (done && flags_we == '0));

    // R6: overflow is only written together with the other flags
    a_r6_ov_with_rest: assert property (@(posedge clk) disable iff (rst)
        flags_we[4] |-> (flags_we[3:0] == 4'hF));

    // R9: multi-step runs pass the incoming overflow through
    a_r9_ov_kept_multi: assert property (@(posedge clk) disable iff (rst)
        (done && flags_we[0] && !flags_we[4]) |-> (flags_out[4] == fin_q.ov));

    // R11: outputs hold between completions
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!zero_req && !last_step) |=> ($stable(result) && $stable(flags_out) && $stable(flags_we) && !done));

    // R11: a strobe during a run leaves the latched operation alone
    a_r11_busy_keeps_op: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(op_q));

endmodule

// File: tb/test_shift_seq_unit.sv
module test_shift_seq_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  op;
    logic        wide;
    logic [15:0] operand;
    logic [7:0]  count;
    logic [4:0]  flags_in;
    logic [15:0] result;
    logic [4:0]  flags_out;
    logic [4:0]  flags_we;
    logic        done;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    shift_seq_unit i_shift_seq_unit (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op        (op),
        .wide      (wide),
        .operand   (operand),
        .count     (count),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out),
        .flags_we  (flags_we),
        .done      (done)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_one(input int opi, input bit wd, input int opnd, input int rawc,
                           input int fin, input bit poke);
        int          w;
        int          n;
        longint      mask;
        longint      v;
        longint      sv;
        longint      res;
        longint      cy;
        longint      ov;
        logic [15:0] rv;
        logic [4:0]  exp_fl;
        logic [4:0]  exp_we;
        logic [15:0] held_res;
        logic [4:0]  held_fl;
        string       rtag;

        w    = wd ? 16 : 8;
        mask = (64'd1 << w) - 1;
        v    = longint'(opnd) & mask;
        n    = rawc & 31;
        res  = v;
        cy   = 0;
        case (opi)
            0: begin
                res = (v << n) & mask;
                cy  = (n > 0 && n <= w) ? ((v >> (w - n)) & 1) : 0;
                rtag = "R2";
            end
            1: begin
                sv  = ((v >> (w - 1)) & 1) != 0 ? v - (64'sd1 << w) : v;
                res = (sv >>> n) & mask;
                cy  = (n > 0) ? ((sv >>> (n - 1)) & 1) : 0;
                rtag = "R3";
            end
            default: begin
                res = v >> n;
                cy  = (n > 0) ? ((v >> (n - 1)) & 1) : 0;
                rtag = "R4";
            end
        endcase
        if (n > w) rtag = "R10";
        if (rawc > 31) rtag = "R1";
        rv = res[15:0];

        if (n == 0) begin
            exp_fl = fin[4:0];
            exp_we = 5'b00000;
            rtag   = "R7";
        end else begin
            if (n == 1) begin
                case (opi)
                    0:       ov = ((v >> (w - 1)) ^ (v >> (w - 2))) & 1;
                    1:       ov = 0;
                    default: ov = (v >> (w - 1)) & 1;
                endcase
                exp_we = 5'b11111;
            end else begin
                ov     = (fin >> 4) & 1;
                exp_we = 5'b01111;
            end
            exp_fl = {ov[0], rv[w-1], (res == 0), ~^rv[7:0], cy[0]};
        end

        @(negedge clk);
        op       = 2'(opi);
        wide     = wd;
        operand  = 16'(opnd);
        count    = 8'(rawc);
        flags_in = 5'(fin);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n; k++) begin
            check("R5 done early", longint'(done), 0);
            if (poke && k == 0 && n >= 2) begin
                start   = 1'b1;
                operand = ~operand;
                count   = 8'd1;
                op      = op + 2'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R5 done", longint'(done), 1);
        check({rtag, " result"}, longint'(result), longint'(rv));
        check(n == 0 ? "R7 flags" : "R8 flags", longint'(flags_out[3:0]), longint'(exp_fl[3:0]));
        check(n == 1 ? "R6 overflow" : (n == 0 ? "R7 overflow" : "R9 overflow"),
              longint'(flags_out[4]), longint'(exp_fl[4]));
        check(n == 0 ? "R7 write mask" : "R8 write mask", longint'(flags_we), longint'(exp_we));
        if (!wd) check("R12 upper byte", longint'(result[15:8]), 0);
        held_res = result;
        held_fl  = flags_out;
        @(negedge clk);
        check("R11 done pulse", longint'(done), 0);
        check("R11 result held", longint'(result), longint'(held_res));
        check("R11 flags held", longint'(flags_out), longint'(held_fl));
    endtask

    function automatic int pick_operand(input int idx, input bit wd);
        case (idx)
            0: return wd ? 16'h8000 : 8'h80;
            1: return wd ? 16'h7FFF : 8'h7F;
            2: return wd ? 16'hC001 : 8'hC1;
            3: return wd ? 16'h4002 : 8'h42;
            4: return wd ? 16'hFFFF : 8'hFF;
            5: return 0;
            default: return (idx * 40503 + 12345) & (wd ? 16'hFFFF : 8'hFF);
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        start    = 1'b0;
        op       = 2'd0;
        wide     = 1'b0;
        operand  = '0;
        count    = '0;
        flags_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset done", longint'(done), 0);
        check("R11 reset write mask", longint'(flags_we), 0);
        check("R11 reset result", longint'(result), 0);

        for (int o = 0; o < 4; o++)
            for (int n = 0; n < 32; n++)
                for (int i = 0; i < 12; i++)
                    run_one(o, 1'b0, pick_operand(i, 1'b0), n + 32 * (i % 8),
                            (i * 7 + n + o) & 31, (i % 3) == 0);

        for (int o = 0; o < 4; o++)
            for (int n = 0; n < 32; n++)
                for (int i = 0; i < 8; i++)
                    run_one(o, 1'b1, pick_operand(i + 2, 1'b1), n + 32 * ((i + n) % 8),
                            (i * 11 + n) & 31, (i % 2) == 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule